// File: doc/BRIEF.md
# Float32 Histogram Binning Engine

This block is the counting core of a histogram unit. A start pulse selects how many bins the run uses and clears every bin counter. The block then takes the bin edges, one float32 word per handshake, and keeps them in a small local register file. The edges must arrive in ascending order. A run with n bins takes n-1 edges.

After the edges come the float32 samples. For each accepted sample the block counts how many loaded edges are at or below it. That number is the bin index, and the block adds one to that bin's 32-bit counter in the same cycle. The sample that carries the last flag ends the sample phase. The block then sends the counters out one per beat, from bin 0 upward, and raises a done flag once the final beat has been taken.

Comparisons follow IEEE-754 ordering for zeros, normals, subnormals and infinities. The block reads and writes no memory itself; a surrounding unit moves the data.

Top module: `fbin_hist`

## Requirements
- R1: While reset is applied, and afterwards until the first start, `edge_ready`, `samp_ready`, `cnt_valid`, `cnt_last` and `done` are all 0.
- R2: A start pulse clears every bin counter and latches `cfg_nbins` as the bin count. A value of 0 is taken as 1, and a value above 32 is taken as 32. A start that arrives in any phase abandons the current run, and a sample handshaken in the same cycle as the start is not counted.
- R3: After a start with bin count n, `edge_ready` stays high until exactly n-1 edges have been accepted. The first accepted edge is edge 0. When n is 1, no edge phase takes place and `samp_ready` rises right after the start.
- R4: `samp_ready` is high only in the sample phase. `edge_ready`, `samp_ready`, `cnt_valid` and `done` are never high at the same time. A sample accepted with `samp_last` = 1 ends the sample phase.
- R5: A non-NaN sample goes into the bin whose index equals the number of loaded edges that are less than or equal to the sample. A sample equal to an edge therefore lands in the higher bin. Bin 0 is open below, and bin n-1 is open above.
- R6: Negative zero (0x80000000) and positive zero (0x00000000) compare as equal. Negative infinity (0xFF800000) falls below every finite edge, and positive infinity (0x7F800000) falls at or above every finite edge.
- R7: A NaN sample (exponent field bits 30:23 all ones and fraction bits 22:0 non-zero, with either sign) is counted in bin n-1.
- R8: After the last sample, the block presents exactly n count beats in bin order 0 to n-1. `cnt_last` is 1 only on the beat for bin n-1. A bin that received no samples reads as 0.
- R9: While `cnt_valid` is high and `cnt_ready` is low, `cnt_valid`, `cnt_data` and `cnt_last` hold their values.
- R10: `done` rises in the cycle after the beat with `cnt_last` is accepted. It stays high until the next start and is low in the cycle that follows a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; the block releases it internally in step with the clock |
| start | input | 1 | One-cycle pulse that begins a new run |
| cfg_nbins | input | 6 | Bin count for the run, latched on start |
| edge_valid | input | 1 | Edge word valid |
| edge_ready | output | 1 | Edge word accepted |
| edge_data | input | 32 | Float32 bin edge |
| samp_valid | input | 1 | Sample valid |
| samp_ready | output | 1 | Sample accepted |
| samp_data | input | 32 | Float32 sample |
| samp_last | input | 1 | Marks the final sample of the run |
| cnt_valid | output | 1 | Count beat valid |
| cnt_ready | input | 1 | Count beat taken |
| cnt_data | output | 32 | Counter value for the current bin |
| cnt_last | output | 1 | Marks the beat for the highest bin |
| done | output | 1 | Run complete |

## Verification
The sample counter increment and the counter clear from start compete for the same edge when a start arrives while a sample is being handshaken. The bench provokes this by raising start with `samp_valid` still high in the sample phase, with the ready side open. It judges the outcome by draining the next run: the counts must match only the samples of the new run. The bench also ends sample phases with samples landing in one bin back to back and with random gaps and count-side stalls. It checks that the first drained beat already includes the final increment.

// File: rtl/fbin_pkg.sv
package fbin_pkg;

  localparam int unsigned F32_W = 32;

  typedef logic [F32_W-1:0] f32_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_EDGE,
    PH_SAMP,
    PH_DRAIN,
    PH_DONE
  } phase_e;

  // Monotonic unsigned key: negative values are inverted, positive values
  // get the sign bit set; negative zero is folded onto positive zero first.
  function automatic f32_t f32_rank_key(input f32_t v);
    f32_t c;
    c = (v == {1'b1, {(F32_W-1){1'b0}}}) ? '0 : v;
    return c[F32_W-1] ? ~c : {1'b1, c[F32_W-2:0]};
  endfunction

  function automatic logic f32_is_nan(input f32_t v);
    return (&v[30:23]) && (|v[22:0]);
  endfunction

endpackage

// File: rtl/fbin_ctrl.sv
module fbin_ctrl
  import fbin_pkg::*;
#(
  parameter int unsigned NBINS_MAX = 32,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned NB_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NB_W-1:0]  cfg_nbins,
  input  logic             edge_fire,
  input  logic             samp_fire,
  input  logic             samp_last,
  input  logic             cnt_ready,
  output phase_e           phase,
  output logic [NB_W-1:0]  nb_q,
  output logic [IDX_W-1:0] widx,
  output logic [IDX_W-1:0] ridx,
  output logic             last_bin
);

  phase_e           phase_q, phase_d;
  logic [NB_W-1:0]  nb_d;
  logic [IDX_W-1:0] widx_q, widx_d, ridx_q, ridx_d;
  logic             nb_en, widx_en, ridx_en;
  logic             last_edge;

  // bin count limiting
  always_comb begin
    nb_d = cfg_nbins;
    if (cfg_nbins == '0)
      nb_d = NB_W'(1);
    else if (cfg_nbins > NB_W'(NBINS_MAX))
      nb_d = NB_W'(NBINS_MAX);
  end

  assign last_edge = (NB_W'(widx_q) + NB_W'(2)) == nb_q;
  assign last_bin  = (NB_W'(ridx_q) + NB_W'(1)) == nb_q;

  // phase sequencing; start overrides any phase
  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_EDGE:  if (edge_fire && last_edge)  phase_d = PH_SAMP;
      PH_SAMP:  if (samp_fire && samp_last)  phase_d = PH_DRAIN;
      PH_DRAIN: if (cnt_ready && last_bin)   phase_d = PH_DONE;
      default:  phase_d = phase_q;
    endcase
    if (start)
      phase_d = (nb_d == NB_W'(1)) ? PH_SAMP : PH_EDGE;
  end

  assign nb_en   = start;
  assign widx_en = start | edge_fire;
  assign widx_d  = start ? '0 : widx_q + IDX_W'(1);
  assign ridx_en = start | ((phase_q == PH_DRAIN) && cnt_ready);
  assign ridx_d  = start ? '0 : ridx_q + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      nb_q    <= NB_W'(1);
      widx_q  <= '0;
      ridx_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (nb_en)   nb_q   <= nb_d;
      if (widx_en) widx_q <= widx_d;
      if (ridx_en) ridx_q <= ridx_d;
    end
  end

  assign phase = phase_q;
  assign widx  = widx_q;
  assign ridx  = ridx_q;

endmodule

// File: rtl/fbin_locate.sv
module fbin_locate
  import fbin_pkg::*;
#(
  parameter int unsigned NBINS_MAX = 32,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned NB_W      = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  f32_t             wr_val,
  input  logic [NB_W-1:0]  nb_q,
  input  f32_t             sample,
  output logic [IDX_W-1:0] bin
);

  localparam int unsigned NEDGE = NBINS_MAX - 1;

  f32_t             samp_key;
  logic [NEDGE-1:0] at_or_below;
  logic [IDX_W-1:0] rank;

  assign samp_key = f32_rank_key(sample);

  for (genvar k = 0; k < NEDGE; k++) begin : g_edge
    f32_t key_q;
    logic sel;
    logic live;

    assign sel  = wr_en && (wr_idx == IDX_W'(k));
    assign live = (NB_W'(k) + NB_W'(1)) < nb_q;

    // edges are stored already converted to rank keys
    always_ff @(posedge clk) begin
      if (sel) key_q <= f32_rank_key(wr_val);
    end

    assign at_or_below[k] = live && (key_q <= samp_key);
  end

  always_comb begin
    rank = '0;
    for (int k = 0; k < NEDGE; k++)
      rank = rank + IDX_W'(at_or_below[k]);
    bin = f32_is_nan(sample) ? IDX_W'(nb_q - NB_W'(1)) : rank;
  end

endmodule

// File: rtl/fbin_counters.sv
module fbin_counters #(
  parameter int unsigned NBINS_MAX = 32,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);

  logic [CNT_W-1:0] bank [NBINS_MAX];

  for (genvar b = 0; b < NBINS_MAX; b++) begin : g_bin
    logic             hit, en;
    logic [CNT_W-1:0] d, q;

    assign hit = inc && (inc_idx == IDX_W'(b));
    assign en  = clear | hit;
    assign d   = clear ? '0 : q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign bank[b] = q;
  end

  assign rd_data = bank[rd_idx];

endmodule

// File: rtl/fbin_hist.sv
module fbin_hist
  import fbin_pkg::*;
#(
  parameter int unsigned NBINS_MAX = 32,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [$clog2(NBINS_MAX+1)-1:0]   cfg_nbins,
  input  logic                             edge_valid,
  output logic                             edge_ready,
  input  logic [31:0]                      edge_data,
  input  logic                             samp_valid,
  output logic                             samp_ready,
  input  logic [31:0]                      samp_data,
  input  logic                             samp_last,
  output logic                             cnt_valid,
  input  logic                             cnt_ready,
  output logic [CNT_W-1:0]                 cnt_data,
  output logic                             cnt_last,
  output logic                             done
);

  localparam int unsigned IDX_W = $clog2(NBINS_MAX);
  localparam int unsigned NB_W  = $clog2(NBINS_MAX + 1);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  phase_e           phase;
  logic [NB_W-1:0]  nb_q;
  logic [IDX_W-1:0] widx, ridx, bin;
  logic             last_bin;
  logic             edge_fire, samp_fire;

  assign edge_ready = (phase == PH_EDGE);
  assign samp_ready = (phase == PH_SAMP);
  assign cnt_valid  = (phase == PH_DRAIN);
  assign done       = (phase == PH_DONE);
  assign cnt_last   = cnt_valid && last_bin;

  assign edge_fire = edge_ready && edge_valid && !start;
  assign samp_fire = samp_ready && samp_valid && !start;

  fbin_ctrl #(
    .NBINS_MAX (NBINS_MAX),
    .IDX_W     (IDX_W),
    .NB_W      (NB_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .cfg_nbins (cfg_nbins),
    .edge_fire (edge_fire),
    .samp_fire (samp_fire),
    .samp_last (samp_last),
    .cnt_ready (cnt_ready),
    .phase     (phase),
    .nb_q      (nb_q),
    .widx      (widx),
    .ridx      (ridx),
    .last_bin  (last_bin)
  );

  fbin_locate #(
    .NBINS_MAX (NBINS_MAX),
    .IDX_W     (IDX_W),
    .NB_W      (NB_W)
  ) u_locate (
    .clk    (clk),
    .wr_en  (edge_fire),
    .wr_idx (widx),
    .wr_val (edge_data),
    .nb_q   (nb_q),
    .sample (samp_data),
    .bin    (bin)
  );

  fbin_counters #(
    .NBINS_MAX (NBINS_MAX),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clear   (start),
    .inc     (samp_fire),
    .inc_idx (bin),
    .rd_idx  (ridx),
    .rd_data (cnt_data)
  );

endmodule

// File: rtl/fbin_hist_chk.sv
module fbin_hist_chk #(
  parameter int unsigned NB_W  = 6,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [NB_W-1:0]  cfg_nbins,
  input logic             edge_ready,
  input logic             samp_ready,
  input logic             cnt_valid,
  input logic             cnt_ready,
  input logic [CNT_W-1:0] cnt_data,
  input logic             cnt_last,
  input logic             done
);

  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({edge_ready, samp_ready, cnt_valid, done}));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_valid && !cnt_ready && !start) |=>
      (cnt_valid && $stable(cnt_data) && $stable(cnt_last)));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_last |-> cnt_valid);

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cnt_valid && cnt_ready && cnt_last && !start));

  // R3
  no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (cfg_nbins <= NB_W'(1))) |=> (!edge_ready && samp_ready));

endmodule

bind fbin_hist fbin_hist_chk #(
  .NB_W  ($clog2(NBINS_MAX + 1)),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .start      (start),
  .cfg_nbins  (cfg_nbins),
  .edge_ready (edge_ready),
  .samp_ready (samp_ready),
  .cnt_valid  (cnt_valid),
  .cnt_ready  (cnt_ready),
  .cnt_data   (cnt_data),
  .cnt_last   (cnt_last),
  .done       (done)
);

// File: tb/fbin_hist_test.sv
`timescale 1ns/1ps
module fbin_hist_test;

  localparam int NBM = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cfg = '0;
  logic        edge_valid = 1'b0;
  logic        edge_ready;
  logic [31:0] edge_data = '0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [31:0] samp_data = '0;
  logic        samp_last = 1'b0;
  logic        cnt_valid;
  logic        cnt_ready = 1'b0;
  logic [31:0] cnt_data;
  logic        cnt_last;
  logic        done;

  always #10 clk = ~clk;

  fbin_hist #(.NBINS_MAX(NBM), .CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_nbins(cfg),
    .edge_valid(edge_valid), .edge_ready(edge_ready), .edge_data(edge_data),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .samp_data(samp_data),
    .samp_last(samp_last), .cnt_valid(cnt_valid), .cnt_ready(cnt_ready),
    .cnt_data(cnt_data), .cnt_last(cnt_last), .done(done)
  );

  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;
  logic [31:0] edb [NBM-1];
  logic [31:0] smp [64];
  int          ns = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  function automatic real f2r(input logic [31:0] b);
    int  e;
    real m, v;
    e = int'(b[30:23]);
    m = real'(b[22:0]);
    if (e == 255)    v = 1.0e300;
    else if (e == 0) v = m * (2.0 ** (-149.0));
    else             v = (1.0 + m / 8388608.0) * (2.0 ** real'(e - 127));
    return b[31] ? -v : v;
  endfunction

  function automatic bit isnan(input logic [31:0] b);
    return (b[30:23] == 8'hFF) && (b[22:0] != '0);
  endfunction

  function automatic logic [31:0] i2f(input int n);
    int a, p;
    logic [31:0] r;
    if (n == 0) return 32'h0;
    a = (n < 0) ? -n : n;
    p = 0;
    for (int i = 0; i < 24; i++) if (a >= (1 << i)) p = i;
    r[31]    = (n < 0);
    r[30:23] = 8'(127 + p);
    r[22:0]  = 23'((a << (23 - p)) & 32'h7FFFFF);
    return r;
  endfunction

  task automatic gen_samples(input int n);
    ns = n;
    for (int s = 0; s < n; s++) begin
      int v;
      step();
      v = int'(lf) % 90;
      if (v < 81) smp[s] = i2f(v - 40);
      else case (v)
        81: smp[s] = 32'h8000_0000;
        82: smp[s] = 32'h7F80_0000;
        83: smp[s] = 32'hFF80_0000;
        84: smp[s] = 32'h7FC0_0000;
        85: smp[s] = 32'h3F00_0000;
        86: smp[s] = 32'hBF00_0000;
        87: smp[s] = 32'h3FC0_0000;
        88: smp[s] = 32'h0000_0000;
        default: smp[s] = 32'hC1A8_0000;
      endcase
    end
  endtask

  task automatic ladder_edges(input int nb);
    for (int k = 0; k < NBM - 1; k++) edb[k] = i2f(2 * k - (nb - 1));
  endtask

  // Full run: start, edges, samples, drain; counts computed from R5..R7 rules.
  task automatic do_run(input int cfgv, input string tag);
    int          nb, b;
    int unsigned expc [NBM];
    bit          stalled;
    nb = (cfgv < 1) ? 1 : ((cfgv > NBM) ? NBM : cfgv);
    for (int i = 0; i < NBM; i++) expc[i] = 0;
    for (int s = 0; s < ns; s++) begin
      int bin;
      if (isnan(smp[s])) bin = nb - 1;
      else begin
        bin = 0;
        for (int k = 0; k < nb - 1; k++) if (f2r(edb[k]) <= f2r(smp[s])) bin++;
      end
      expc[bin]++;
    end
    @(negedge clk);
    start = 1'b1; cfg = 6'(cfgv);
    @(negedge clk);
    start = 1'b0; samp_valid = 1'b0; samp_last = 1'b0;
    chk(done == 1'b0, "R10", 32'(done), 32'd0);
    if (nb == 1) chk(!edge_ready && samp_ready, "R3", {edge_ready, samp_ready}, 32'b01);
    for (int k = 0; k < nb - 1; k++) begin
      edge_valid = 1'b1; edge_data = edb[k];
      chk(edge_ready && !samp_ready, "R3", {edge_ready, samp_ready}, 32'b10);
      @(negedge clk);
    end
    edge_valid = 1'b0;
    chk(!edge_ready && samp_ready, "R4", {edge_ready, samp_ready}, 32'b01);
    for (int s = 0; s < ns; s++) begin
      step();
      if (lf[0] && lf[1]) begin samp_valid = 1'b0; @(negedge clk); end
      samp_valid = 1'b1; samp_data = smp[s]; samp_last = (s == ns - 1);
      @(negedge clk);
    end
    samp_valid = 1'b0; samp_last = 1'b0;
    b = 0; stalled = 1'b0;
    while (b < nb) begin
      chk(cnt_valid && !samp_ready, "R4", {cnt_valid, samp_ready}, 32'b10);
      chk(cnt_data == expc[b], stalled ? "R9" : tag, cnt_data, expc[b]);
      chk(cnt_last == (b == nb - 1), "R8", 32'(cnt_last), 32'(b == nb - 1));
      step();
      cnt_ready = (lf[2:0] != 3'b000);
      stalled = !cnt_ready;
      if (cnt_ready) b++;
      @(negedge clk);
    end
    cnt_ready = 1'b0;
    chk(done && !cnt_valid, "R10", {done, cnt_valid}, 32'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({edge_ready, samp_ready, cnt_valid, cnt_last, done} == '0, "R1",
        {edge_ready, samp_ready, cnt_valid, cnt_last, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({edge_ready, samp_ready, cnt_valid, cnt_last, done} == '0, "R1",
        {edge_ready, samp_ready, cnt_valid, cnt_last, done}, 32'd0);

    // R5 sweep over every bin count with integer-ladder edges
    for (int nb = 1; nb <= NBM; nb++) begin
      ladder_edges(nb);
      gen_samples(40);
      do_run(nb, "R5");
    end

    // R6 signed zero and infinities
    edb[0] = 32'h8000_0000; edb[1] = 32'h3F80_0000;
    ns = 7;
    smp[0] = 32'h0000_0000; smp[1] = 32'h8000_0000; smp[2] = 32'hBF80_0000;
    smp[3] = 32'h3F80_0000; smp[4] = 32'h7F80_0000; smp[5] = 32'hFF80_0000;
    smp[6] = 32'h0000_0001;
    do_run(3, "R6");

    // R7 NaN of both signs goes to the top bin
    edb[0] = i2f(-2); edb[1] = i2f(-1); edb[2] = i2f(1); edb[3] = i2f(2);
    ns = 5;
    smp[0] = 32'h7FC0_0000; smp[1] = 32'hFFC0_0001; smp[2] = 32'h7F80_0001;
    smp[3] = 32'h0000_0000; smp[4] = 32'hFFFF_FFFF;
    do_run(5, "R7");
    ns = 2; smp[0] = 32'h7FC0_0000; smp[1] = i2f(-9);
    do_run(1, "R7");

    // R2 clamping of the bin count
    ns = 3; smp[0] = i2f(5); smp[1] = 32'h7FC0_0000; smp[2] = i2f(-5);
    do_run(0, "R2");
    ladder_edges(NBM);
    gen_samples(30);
    do_run(45, "R2");

    // R2 restart mid-run: start lands on a live sample handshake
    ladder_edges(4);
    @(negedge clk); start = 1'b1; cfg = 6'd4;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      edge_valid = 1'b1; edge_data = edb[k];
      @(negedge clk);
    end
    edge_valid = 1'b0;
    for (int s = 0; s < 5; s++) begin
      samp_valid = 1'b1; samp_data = i2f(s - 2); samp_last = 1'b0;
      @(negedge clk);
    end
    samp_data = i2f(3);
    ns = 6;
    for (int s = 0; s < 6; s++) smp[s] = i2f(3 * s - 7);
    do_run(4, "R2");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule